// File: doc/BRIEF.md
# Radix-4 Montgomery Partition Core

This block is the datapath of one partition in a parallel Montgomery multiplier. It accumulates a Montgomery product, taking one 2-bit digit of the multiplier per cycle. In each working cycle it turns the digit into a multiple of the multiplicand: zero, Y, 2Y, or a 3Y value that the caller computes beforehand. It adds that multiple to the running accumulator. It then forms a quotient digit from the low byte of the new sum times the modulus-inverse constant, adds that quotient times the modulus, and shifts the whole value down by one quotient digit.

A parent block raises `start`, then feeds digits while `take` is high, least-significant digit first. After a fixed number of iterations the core raises `done` and holds its partial result until the next start. Sibling partitions feed interleaved digits of the same multiplier, and the parent adds their outputs together. That summation and the final reduction are not part of this core.

Top module: `mont4_partition_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `take`, `done` and `result` are all zero.
- R2: A `start` sampled while the core is idle or finished moves it to a one-cycle clear step. In that step `take` and `done` are both low.
- R3: After the clear step, `take` is high for exactly ITERS cycles. `done` rises on the clock edge that consumes the last digit, and `take` and `done` are never high together.
- R4: The digit code selects the addend: 2'b00 gives 0, 2'b01 gives `y`, 2'b10 gives `y` shifted left by one, and 2'b11 gives the `y3` input as supplied.
- R5: Each consumed digit updates the accumulator A as follows. Let s = A + addend and q = (s mod 2^QW) * `mprime` mod 2^QW. The new value is A' = (s + q*`m`) / 2^QW, and the division is exact.
- R6: With digit d_i consumed in the i-th `take` cycle, let X = sum of d_i * 2^(QW*i). The final `result` satisfies result * 2^(QW*ITERS) ≡ X*Y (mod m), provided `m` is odd, `mprime` * `m` ≡ -1 (mod 2^QW) and `y3` = 3·`y`.
- R7: With `y` < `m` and `y3` = 3·`y`, the final `result` is less than 2·`m`.
- R8: While finished, `done` stays high and `result` stays stable until a new `start`, whatever the digit input does. A `start` raised while `take` is high is ignored and does not change the outcome.
- R9: A restart from the finished state lowers `done` and clears the accumulator. `result` reads zero in the first `take` cycle, whatever the previous result was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new accumulation (ignored while working) |
| digit | input | 2 | Multiplier digit, consumed while `take` is high |
| y | input | W | Multiplicand |
| y3 | input | W+2 | Precomputed triple of the multiplicand |
| m | input | W | Odd modulus |
| mprime | input | QW | Negated inverse of `m` modulo 2^QW |
| take | output | 1 | Digit on `digit` is consumed at the next edge |
| done | output | 1 | Partial result valid |
| result | output | W+10 | Accumulator / partial Montgomery result |

## Verification
The bench runs a reduced 8-bit configuration with three iterations and sweeps every digit pattern over a range of moduli, each paired with multiplicands from zero up to m−1. A wrong quotient or a wrong shift would leave nonzero low bits and break both the exact-value check and the modular congruence. A swapped or wrongly weighted digit code shows up in targeted runs that put a single nonzero digit last and feed a `y3` that is not 3·`y`. An off-by-one in the iteration count moves the edge where `done` rises or the edge where `take` falls. A missing clear on restart leaves the previous result in the first working cycle. A held result that drifts, or a start inside a run that is not ignored, would change values the bench reads during the finished state.

// File: rtl/mont4_pkg.sv
package mont4_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLEAR = 2'd1,
    PH_RUN   = 2'd2,
    PH_FIN   = 2'd3
  } phase_t;
endpackage

// File: rtl/mont4_digit_sel.sv
module mont4_digit_sel #(
  parameter int W     = 1024,
  parameter int ACC_W = W + 10
) (
  input  logic [1:0]       digit,
  input  logic [W-1:0]     y,
  input  logic [W+1:0]     y3,
  output logic [ACC_W-1:0] addend
);
  always_comb begin
    unique case (digit)
      2'b00:   addend = '0;
      2'b01:   addend = ACC_W'(y);
      2'b10:   addend = ACC_W'({y, 1'b0});
      default: addend = ACC_W'(y3);
    endcase
  end
endmodule

// File: rtl/mont4_reduce_step.sv
module mont4_reduce_step #(
  parameter int W     = 1024,
  parameter int QW    = 8,
  parameter int ACC_W = W + 10
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] addend,
  input  logic [W-1:0]     m,
  input  logic [QW-1:0]    mprime,
  output logic [ACC_W-1:0] acc_next,
  output logic [QW-1:0]    low_rem
);
  logic [ACC_W-1:0] sum_a;
  logic [QW-1:0]    qdig;
  logic [ACC_W-1:0] qm;
  logic [ACC_W-1:0] sum_b;

  assign sum_a    = acc + addend;
  assign qdig     = QW'(sum_a[QW-1:0] * mprime);
  assign qm       = ACC_W'(qdig) * ACC_W'(m);
  assign sum_b    = sum_a + qm;
  assign acc_next = sum_b >> QW;
  assign low_rem  = sum_b[QW-1:0];
endmodule

// File: rtl/mont4_seq_ctrl.sv
module mont4_seq_ctrl
  import mont4_pkg::*;
#(
  parameter int ITERS = 128,
  localparam int CW   = $clog2(ITERS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic clear_now,
  output logic take_q,
  output logic done_q
);
  phase_t        ph;
  logic [CW-1:0] cnt;

  assign clear_now = (ph == PH_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      take_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE, PH_FIN: begin
          if (start) begin
            ph     <= PH_CLEAR;
            done_q <= 1'b0;
          end
        end
        PH_CLEAR: begin
          ph     <= PH_RUN;
          cnt    <= '0;
          take_q <= 1'b1;
        end
        default: begin
          if (cnt == CW'(ITERS - 1)) begin
            ph     <= PH_FIN;
            take_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(take_q && done_q));

  a_r2_clear_quiet: assert property (@(posedge clk) disable iff (rst)
    clear_now |-> (!take_q && !done_q));
endmodule

// File: rtl/mont4_partition_core.sv
module mont4_partition_core #(
  parameter int W      = 1024,
  parameter int ITERS  = 128,
  parameter int QW     = 8,
  localparam int ACC_W = W + 10,
  localparam int CW    = $clog2(ITERS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       digit,
  input  logic [W-1:0]     y,
  input  logic [W+1:0]     y3,
  input  logic [W-1:0]     m,
  input  logic [QW-1:0]    mprime,
  output logic             take,
  output logic             done,
  output logic [ACC_W-1:0] result
);
  logic             clear_now;
  logic             take_q;
  logic             done_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] acc_next;
  logic [QW-1:0]    low_rem;

  mont4_seq_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .clear_now (clear_now),
    .take_q    (take_q),
    .done_q    (done_q)
  );

  mont4_digit_sel #(.W(W), .ACC_W(ACC_W)) u_sel (
    .digit  (digit),
    .y      (y),
    .y3     (y3),
    .addend (addend)
  );

  mont4_reduce_step #(.W(W), .QW(QW), .ACC_W(ACC_W)) u_step (
    .acc      (acc_q),
    .addend   (addend),
    .m        (m),
    .mprime   (mprime),
    .acc_next (acc_next),
    .low_rem  (low_rem)
  );

  always_ff @(posedge clk) begin
    if (rst || clear_now) acc_q <= '0;
    else if (take_q)      acc_q <= acc_next;
  end

  assign take   = take_q;
  assign done   = done_q;
  assign result = acc_q;

  // window counter for the iteration-length check
  logic [CW:0] win_cnt;
  always_ff @(posedge clk) begin
    if (rst || clear_now) win_cnt <= '0;
    else if (take_q)      win_cnt <= win_cnt + 1'b1;
  end

  // R5: quotient digit cancels the low digit before the shift
  a_r5_exact_shift: assert property (@(posedge clk) disable iff (rst)
    take_q |-> (low_rem == '0));

  a_r3_iter_count: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (win_cnt == (CW+1)'(ITERS)));

  a_r9_cleared: assert property (@(posedge clk) disable iff (rst)
    clear_now |=> (acc_q == '0 && take_q));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> (done_q && $stable(acc_q)));
endmodule

// File: tb/tb_mont4_partition_core.sv
module tb_mont4_partition_core;
  localparam int W     = 8;
  localparam int ITERS = 3;
  localparam int QW    = 8;
  localparam int ACC_W = W + 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [1:0]       digit = 2'b00;
  logic [W-1:0]     y = '0;
  logic [W+1:0]     y3 = '0;
  logic [W-1:0]     m = 8'd3;
  logic [QW-1:0]    mprime = '0;
  logic             take;
  logic             done;
  logic [ACC_W-1:0] result;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mont4_partition_core #(.W(W), .ITERS(ITERS), .QW(QW)) dut (
    .clk(clk), .rst(rst), .start(start), .digit(digit), .y(y), .y3(y3),
    .m(m), .mprime(mprime), .take(take), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint inv_neg(input longint mv);
    for (int k = 0; k < 256; k++)
      if (((mv * k) + 1) % 256 == 0) return longint'(k);
    return 0;
  endfunction

  function automatic longint addend_of(input logic [1:0] d, input longint yv, input longint y3v);
    case (d)
      2'b00:   return 0;
      2'b01:   return yv;
      2'b10:   return 2 * yv;
      default: return y3v;
    endcase
  endfunction

  function automatic longint model(input logic [2*ITERS-1:0] xb, input longint yv,
                                   input longint y3v, input longint mv, input longint mp);
    longint a = 0;
    for (int i = 0; i < ITERS; i++) begin
      longint s = a + addend_of(xb[2*i +: 2], yv, y3v);
      longint q = ((s % 256) * mp) % 256;
      a = (s + q * mv) / 256;
    end
    return a;
  endfunction

  task automatic run(input logic [2*ITERS-1:0] xb, input longint yv, input longint y3v,
                     input longint mv, input bit midstart, input bit r4_case);
    longint mp = inv_neg(mv);
    longint expv = model(xb, yv, y3v, mv, mp);
    longint got;
    longint e = 0;
    @(negedge clk);
    m = W'(mv); y = W'(yv); y3 = (W+2)'(y3v); mprime = QW'(mp);
    digit = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(take == 1'b0 && done == 1'b0, "R2", longint'({take, done}), 0);
    @(negedge clk);
    chk(take == 1'b1, "R3", longint'(take), 1);
    chk(result == '0, "R9", longint'(result), 0);
    for (int i = 0; i < ITERS; i++) begin
      digit = xb[2*i +: 2];
      start = (midstart && i == 1);
      if (i == ITERS - 1) chk(done == 1'b0, "R3", longint'(done), 0);
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1 && take == 1'b0, "R3", longint'({done, take}), 2);
    got = longint'(result);
    if (r4_case) chk(got == expv, "R4", got, expv);
    else if (midstart) chk(got == expv, "R8", got, expv);
    else chk(got == expv, "R5", got, expv);
    if (y3v == 3 * yv) begin
      for (int i = 0; i < ITERS; i++) e += addend_of(xb[2*i +: 2], yv, y3v) << (8 * i);
      chk(((got << (8 * ITERS)) % mv) == (e % mv), "R6", (got << (8 * ITERS)) % mv, e % mv);
      if (yv < mv) chk(got < 2 * mv, "R7", got, 2 * mv);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint mods [4] = '{3, 13, 129, 255};
    repeat (3) @(negedge clk);
    chk(take == 1'b0 && done == 1'b0 && result == '0, "R1", longint'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(take == 1'b0 && done == 1'b0 && result == '0, "R1", longint'(result), 0);

    // R4: single nonzero last digit, with y3 not equal to 3y
    for (int c = 0; c < 4; c++) begin
      logic [2*ITERS-1:0] xb = '0;
      xb[2*(ITERS-1) +: 2] = 2'(c);
      run(xb, 100, 77, 201, 1'b0, 1'b1);
    end

    // main sweep (R5, R6, R7, R9 via back-to-back restarts)
    foreach (mods[k]) begin
      longint mv = mods[k];
      longint ystep = (mv > 200) ? 17 : 1;
      for (longint yv = 0; yv < mv; yv += ystep) begin
        for (int x = 0; x < (1 << (2 * ITERS)); x++)
          run((2*ITERS)'(x), yv, 3 * yv, mv, (x % 16) == 5, 1'b0);
      end
      run('1, mv - 1, 3 * (mv - 1), mv, 1'b0, 1'b0);
    end

    // R8: held result while finished, digit toggling
    begin
      logic [ACC_W-1:0] held;
      run(6'b111001, 200, 600, 255, 1'b0, 1'b0);
      held = result;
      for (int i = 0; i < 4; i++) begin
        digit = 2'(i);
        @(negedge clk);
        chk(done == 1'b1 && result == held, "R8", longint'(result), longint'(held));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule